// File: doc/BRIEF.md
# Per-Subclass Pending I/O Interrupt Store

This block keeps pending I/O interrupts sorted into eight subclass stacks. An injected interrupt carries a 16-bit subchannel identifier, a 16-bit subchannel number, a 32-bit parameter and a 32-bit interrupt word. The word's subclass field, bits [29:27], selects the stack that receives the entry. Each stack keeps its most recent entry on top and holds a fixed number of entries.

A consumer sets an 8-bit subclass enable vector. It can request a dequeue, which returns the newest entry of the lowest-numbered enabled subclass that has work. A clear request removes every entry whose identifier and number both match, whatever its subclass. A pending summary shows one bit per non-empty subclass. A has-work output shows whether any enabled subclass is pending.

The three request ports and the response port use valid/ready handshakes. Only one request is accepted per cycle. Clear always wins and `clr_ready` is tied high. A dequeue request is next: `deq_ready` is low while a clear is requested, and also while an earlier response is still waiting on `rsp_ready`. Inject comes last: `inj_ready` is low whenever a clear or a dequeue is requested. A response stays on the port, unchanged, until `rsp_ready` takes it.

Top module: `io_irq_store`

## Requirements
- R1: An accepted inject into a non-full stack stores the entry in the stack named by `inj_word[29:27]`. The matching `pending` bit reads 1 from the next cycle on.
- R2: Within one subclass, entries leave in the reverse of their inject order.
- R3: An accepted dequeue returns, one cycle later, the top entry of the lowest-numbered subclass whose `sub_enable` bit is set and whose stack is not empty. The response has `rsp_found`=1.
- R4: An accepted dequeue with no enabled pending subclass returns `rsp_found`=0 with all data fields zero, and changes no stack.
- R5: A `pending` bit falls only in the cycle after its stack becomes empty.
- R6: An accepted clear removes, in every subclass, each entry whose id and number both equal `clr_id`/`clr_nr`. Entries that match in only one of the two fields stay. Surviving entries keep their order, and `pending` is updated in the next cycle.
- R7: A clear while nothing is pending leaves `pending` at zero and has no other effect.
- R8: Reset (`rst_n` low) empties every stack and clears `pending`, `rsp_valid` and `inj_ovf`.
- R9: Each stack holds 4 entries. An inject into a full stack is accepted but not stored, leaves the stack unchanged, and pulses `inj_ovf` high for the one cycle after acceptance.
- R10: `has_work` equals the OR of `pending & sub_enable` in the same cycle.
- R11: At most one request is accepted per cycle, with priority clear, then dequeue, then inject.
- R12: While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `deq_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_enable | input | 8 | Subclass enable vector for dequeue and has_work |
| inj_valid | input | 1 | Inject request valid |
| inj_ready | output | 1 | Inject request accepted this cycle |
| inj_id | input | 16 | Subchannel identifier of injected entry |
| inj_nr | input | 16 | Subchannel number of injected entry |
| inj_parm | input | 32 | Interrupt parameter |
| inj_word | input | 32 | Interrupt word, subclass in bits [29:27] |
| inj_ovf | output | 1 | One-cycle pulse: last inject hit a full stack |
| deq_valid | input | 1 | Dequeue request valid |
| deq_ready | output | 1 | Dequeue request accepted this cycle |
| rsp_valid | output | 1 | Dequeue response valid |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_found | output | 1 | Response carries an entry |
| rsp_id | output | 16 | Returned identifier |
| rsp_nr | output | 16 | Returned number |
| rsp_parm | output | 32 | Returned parameter |
| rsp_word | output | 32 | Returned interrupt word |
| clr_valid | input | 1 | Clear request valid |
| clr_ready | output | 1 | Clear request accepted (always 1) |
| clr_id | input | 16 | Identifier to remove |
| clr_nr | input | 16 | Number to remove |
| pending | output | 8 | One bit per non-empty subclass |
| has_work | output | 1 | Some enabled subclass is pending |

## Verification
A wrong stack depth counter shows up first in `pending`, in the cycle after the faulty operation. A wrong counter also shows as a missing or spurious `inj_ovf` on the next inject into that subclass. Damage to the stored entries or to the compaction done by a clear stays hidden until a dequeue reaches that entry. The dequeue order is therefore checked entry by entry against a scoreboard, including after clears that remove entries from the middle of a stack. Mistakes in the priority choice or in the handshake show in the response one cycle after the request.

// File: rtl/io_irq_pkg.sv
package io_irq_pkg;
  typedef struct packed {
    logic [15:0] id;
    logic [15:0] nr;
    logic [31:0] parm;
    logic [31:0] word;
  } irq_entry_t;
endpackage

// File: rtl/irq_lifo.sv
module irq_lifo
  import io_irq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic        pop,
  input  logic        clr,
  input  logic [15:0] clr_id,
  input  logic [15:0] clr_nr,
  input  irq_entry_t  din,
  output irq_entry_t  head,
  output logic        empty,
  output logic        full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  irq_entry_t    mem      [DEPTH];
  irq_entry_t    keep_mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] keep_cnt;

  // compaction: survivors slide down, order kept
  always_comb begin
    int k;
    k = 0;
    keep_mem = mem;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt && !(mem[i].id == clr_id && mem[i].nr == clr_nr)) begin
        keep_mem[AW'(k)] = mem[i];
        k++;
      end
    end
    keep_cnt = CW'(k);
  end

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = empty ? '0 : mem[AW'(cnt - CW'(1))];

  always_ff @(posedge clk) begin
    if (clr) mem <= keep_mem;
    else if (push && !full && !pop) mem[AW'(cnt)] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= keep_cnt;
    else if (pop && !empty)    cnt <= cnt - CW'(1);
    else if (push && !full)    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/io_irq_store.sv
module io_irq_store
  import io_irq_pkg::*;
#(
  parameter int NSUB    = 8,
  parameter int DEPTH   = 4,
  parameter int SUB_LSB = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSUB-1:0] sub_enable,
  input  logic            inj_valid,
  output logic            inj_ready,
  input  logic [15:0]     inj_id,
  input  logic [15:0]     inj_nr,
  input  logic [31:0]     inj_parm,
  input  logic [31:0]     inj_word,
  output logic            inj_ovf,
  input  logic            deq_valid,
  output logic            deq_ready,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_found,
  output logic [15:0]     rsp_id,
  output logic [15:0]     rsp_nr,
  output logic [31:0]     rsp_parm,
  output logic [31:0]     rsp_word,
  input  logic            clr_valid,
  output logic            clr_ready,
  input  logic [15:0]     clr_id,
  input  logic [15:0]     clr_nr,
  output logic [NSUB-1:0] pending,
  output logic            has_work
);
  localparam int SW = (NSUB > 1) ? $clog2(NSUB) : 1;

  logic            inj_fire, deq_fire;
  logic [SW-1:0]   inj_sub, pick_idx;
  logic            pick_found;
  logic [NSUB-1:0] full_v, empty_v;
  irq_entry_t      heads [NSUB];
  irq_entry_t      din, sel, rsp_q;
  logic            rsp_v_q, found_q, ovf_q;

  // request arbitration: clear > dequeue > inject
  assign clr_ready = 1'b1;
  assign deq_ready = !clr_valid && (!rsp_v_q || rsp_ready);
  assign inj_ready = !clr_valid && !deq_valid;
  assign deq_fire  = deq_valid && deq_ready;
  assign inj_fire  = inj_valid && inj_ready;

  assign inj_sub = inj_word[SUB_LSB +: SW];
  assign din     = '{id: inj_id, nr: inj_nr, parm: inj_parm, word: inj_word};

  irq_pick #(.N(NSUB), .IW(SW)) u_pick (
    .req   (pending & sub_enable),
    .found (pick_found),
    .idx   (pick_idx)
  );

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    irq_lifo #(.DEPTH(DEPTH)) u_lifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (inj_fire && inj_sub == SW'(g)),
      .pop    (deq_fire && pick_found && pick_idx == SW'(g)),
      .clr    (clr_valid),
      .clr_id (clr_id),
      .clr_nr (clr_nr),
      .din    (din),
      .head   (heads[g]),
      .empty  (empty_v[g]),
      .full   (full_v[g])
    );
    assign pending[g] = !empty_v[g];
  end

  assign sel      = heads[pick_idx];
  assign has_work = |(pending & sub_enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      found_q <= 1'b0;
      rsp_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= inj_fire && full_v[inj_sub];
      if (deq_fire) begin
        rsp_v_q <= 1'b1;
        found_q <= pick_found;
        rsp_q   <= pick_found ? sel : '0;
      end else if (rsp_ready) begin
        rsp_v_q <= 1'b0;
      end
    end
  end

  assign inj_ovf   = ovf_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_found = found_q;
  assign rsp_id    = rsp_q.id;
  assign rsp_nr    = rsp_q.nr;
  assign rsp_parm  = rsp_q.parm;
  assign rsp_word  = rsp_q.word;
endmodule

// File: rtl/io_irq_store_chk.sv
module io_irq_store_chk #(
  parameter int NSUB = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSUB-1:0] sub_enable,
  input logic            inj_valid,
  input logic            inj_ready,
  input logic            inj_ovf,
  input logic            deq_valid,
  input logic            deq_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_found,
  input logic [15:0]     rsp_id,
  input logic [31:0]     rsp_word,
  input logic            clr_valid,
  input logic            clr_ready,
  input logic [NSUB-1:0] pending
);
  // R11
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_valid && clr_ready, deq_valid && deq_ready, inj_valid && inj_ready}));

  // R9
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ovf |-> $past(inj_valid && inj_ready));

  // R1
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending & ~$past(pending))) |-> $past(inj_valid && inj_ready));

  // R7
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && pending == '0) |=> pending == '0);

  // R4
  deq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_ready && (pending & sub_enable) == '0) |=> rsp_valid && !rsp_found);

  // R3
  deq_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_ready && (pending & sub_enable) != '0) |=> rsp_valid && rsp_found);

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable({rsp_found, rsp_id, rsp_word}));
endmodule

bind io_irq_store io_irq_store_chk #(.NSUB(NSUB)) u_chk (.*);

// File: tb/io_irq_store_tb.sv
module io_irq_store_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sub_enable = 8'hFF;
  logic        inj_valid = 1'b0, inj_ready;
  logic [15:0] inj_id = '0, inj_nr = '0;
  logic [31:0] inj_parm = '0, inj_word = '0;
  logic        inj_ovf;
  logic        deq_valid = 1'b0, deq_ready;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_found;
  logic [15:0] rsp_id, rsp_nr;
  logic [31:0] rsp_parm, rsp_word;
  logic        clr_valid = 1'b0, clr_ready;
  logic [15:0] clr_id = '0, clr_nr = '0;
  logic [7:0]  pending;
  logic        has_work;

  always #5 clk = ~clk;

  io_irq_store u_dut (.*);

  int checks = 0;
  int fails = 0;
  logic [95:0] m_st [8][4];
  int          m_cnt [8];
  logic [96:0] sb [$];

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(int s, int tag);
    return (32'(s) << 27) | 32'(tag & 'hFFF);
  endfunction

  function automatic logic [7:0] m_pend();
    logic [7:0] p;
    for (int g = 0; g < 8; g++) p[g] = (m_cnt[g] != 0);
    return p;
  endfunction

  task automatic inject(int s, logic [15:0] id, logic [15:0] nr, int tag, string req);
    logic exp_ovf;
    @(negedge clk);
    inj_valid = 1'b1; inj_id = id; inj_nr = nr;
    inj_parm = 32'(tag) * 32'h101; inj_word = mkword(s, tag);
    exp_ovf = (m_cnt[s] == 4);
    if (!exp_ovf) begin
      m_st[s][m_cnt[s]] = {id, nr, inj_parm, inj_word};
      m_cnt[s]++;
    end
    @(negedge clk);
    inj_valid = 1'b0;
    chk({req, " ovf"}, 128'(inj_ovf), 128'(exp_ovf));
  endtask

  task automatic dequeue();
    logic [96:0] e;
    e = '0;
    @(negedge clk);
    deq_valid = 1'b1;
    for (int g = 0; g < 8; g++) begin
      if (e[96] == 1'b0 && sub_enable[g] && m_cnt[g] > 0) begin
        m_cnt[g]--;
        e = {1'b1, m_st[g][m_cnt[g]]};
      end
    end
    sb.push_back(e);
    @(negedge clk);
    deq_valid = 1'b0;
  endtask

  task automatic clear(logic [15:0] id, logic [15:0] nr);
    @(negedge clk);
    clr_valid = 1'b1; clr_id = id; clr_nr = nr;
    for (int g = 0; g < 8; g++) begin
      int k;
      k = 0;
      for (int i = 0; i < m_cnt[g]; i++) begin
        if (!(m_st[g][i][95:80] == id && m_st[g][i][79:64] == nr)) begin
          m_st[g][k] = m_st[g][i];
          k++;
        end
      end
      m_cnt[g] = k;
    end
    @(negedge clk);
    clr_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 actual=unexpected response expected=none");
      end else begin
        logic [96:0] e;
        e = sb.pop_front();
        chk("R3/R4/R2 response", 128'({rsp_found, rsp_id, rsp_nr, rsp_parm, rsp_word}), 128'(e));
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    for (int g = 0; g < 8; g++) m_cnt[g] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 pending", 128'(pending), 128'(0));
    chk("R8 rsp_valid", 128'(rsp_valid), 128'(0));
    chk("R8 inj_ovf", 128'(inj_ovf), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 has_work idle", 128'(has_work), 128'(0));

    // R1, R2, R3, R5
    inject(3, 16'h0A, 16'h1, 1, "R1");
    inject(3, 16'h0B, 16'h2, 2, "R1");
    inject(1, 16'h0C, 16'h3, 3, "R1");
    chk("R1 pending", 128'(pending), 128'(8'h0A));
    chk("R10 has_work", 128'(has_work), 128'(1));
    dequeue();
    dequeue();
    chk("R5 still pending", 128'(pending), 128'(8'h08));
    dequeue();
    chk("R5 emptied", 128'(pending), 128'(0));

    // R4, R10 with masks
    inject(2, 16'h0D, 16'h4, 4, "R1");
    @(negedge clk); sub_enable = 8'h00; #1;
    chk("R10 masked", 128'(has_work), 128'(0));
    dequeue();
    sub_enable = 8'h08;
    dequeue();
    chk("R4 unchanged", 128'(pending), 128'(8'h04));
    sub_enable = 8'h04;
    dequeue();
    sub_enable = 8'hFF;

    // R9 overflow
    for (int t = 0; t < 4; t++) inject(5, 16'h50, 16'(t), 16 + t, "R9");
    inject(5, 16'h5F, 16'h5F, 31, "R9 full");
    for (int t = 0; t < 4; t++) dequeue();
    chk("R9 drained", 128'(pending), 128'(0));

    // R6 clear
    inject(0, 16'h1, 16'h1, 40, "R6");
    inject(0, 16'h2, 16'h2, 41, "R6");
    inject(0, 16'h1, 16'h1, 42, "R6");
    inject(0, 16'h3, 16'h3, 43, "R6");
    inject(6, 16'h1, 16'h1, 44, "R6");
    inject(6, 16'h1, 16'h9, 45, "R6");
    clear(16'h1, 16'h1);
    chk("R6 pending after clear", 128'(pending), 128'(8'h41));
    clear(16'h3, 16'h3);
    clear(16'h2, 16'h2);
    chk("R6 sub0 gone", 128'(pending), 128'(8'h40));
    dequeue();
    chk("R6 empty", 128'(pending), 128'(0));

    // R7 clear with nothing pending
    clear(16'h7, 16'h7);
    chk("R7 pending", 128'(pending), 128'(0));
    dequeue();

    // R12 back-pressure
    inject(4, 16'h40, 16'h41, 50, "R12");
    inject(4, 16'h42, 16'h43, 51, "R12");
    rsp_ready = 1'b0;
    dequeue();
    chk("R12 rsp_valid", 128'(rsp_valid), 128'(1));
    deq_valid = 1'b1; #1;
    chk("R12 deq_ready", 128'(deq_ready), 128'(0));
    deq_valid = 1'b0;
    @(negedge clk);
    chk("R12 hold valid", 128'(rsp_valid), 128'(1));
    chk("R12 hold data", 128'({rsp_id, rsp_nr}), 128'({16'h42, 16'h43}));
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 released", 128'(rsp_valid), 128'(0));
    dequeue();

    // R11 priority
    @(negedge clk);
    clr_valid = 1'b1; deq_valid = 1'b1; inj_valid = 1'b1; #1;
    chk("R11 clr wins", 128'({clr_ready, deq_ready, inj_ready}), 128'(3'b100));
    clr_valid = 1'b0; #1;
    chk("R11 deq over inj", 128'({deq_ready, inj_ready}), 128'(2'b10));
    deq_valid = 1'b0; inj_valid = 1'b0;

    // R8 reset mid-run
    inject(7, 16'h70, 16'h71, 60, "R8");
    inject(2, 16'h72, 16'h73, 61, "R8");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 flushed", 128'(pending), 128'(0));
    rst_n = 1'b1;
    for (int g = 0; g < 8; g++) m_cnt[g] = 0;
    dequeue();
    repeat (3) @(negedge clk);
    chk("scoreboard empty", 128'(sb.size()), 128'(0));
    finish_up();
  end
endmodule